// File: doc/BRIEF.md
# Pixel Clock Program Word Calculator

This block turns a requested pixel frequency, given in hundredths of a megahertz, into the program word for a clock synthesizer that is loaded serially. A request is one cycle of `start_i` with the frequency on `freq_i`. The block first checks the request against the legal range. It then doubles the frequency until it lies in the VCO band, doubling a post-divider along with it. Next it finds the feedback count against the fixed reference using a rounded integer divide. Finally it packs the count, a post-divider code and two fixed stop bits into one word. A single serial divider does both divides, one quotient bit per clock.

The controller is one state machine with these states:

- `ST_IDLE`: waits for a request.
- `ST_CHECK`: range test.
- `ST_REJECT`: error result.
- `ST_NORM`: one doubling per cycle.
- `ST_SCALE` and `ST_SCALE_WAIT`: first divide, by the reference.
- `ST_ROUND` and `ST_ROUND_WAIT`: second divide, with rounding.
- `ST_EMIT`: result.

Its transitions are:

- request accepted: `ST_IDLE` to `ST_CHECK`.
- out of range: `ST_CHECK` to `ST_REJECT` to `ST_IDLE`.
- in range: `ST_CHECK` to `ST_NORM`.
- band reached: `ST_NORM` to `ST_SCALE`.
- launch: `ST_SCALE` to `ST_SCALE_WAIT`.
- quotient ready: `ST_SCALE_WAIT` to `ST_ROUND`.
- launch: `ST_ROUND` to `ST_ROUND_WAIT`.
- quotient ready: `ST_ROUND_WAIT` to `ST_EMIT`.
- publish: `ST_EMIT` to `ST_IDLE`.

Top module: `clk_word_calc`

## Requirements
- R1: After reset `done_o` and `err_o` are 0, `word_o` is 0x0000 and `postdiv_o` is 0.
- R2: A request above 15938 or below 1000 ends with a one-cycle `done_o` and `err_o`=1, and leaves `word_o` and `postdiv_o` at their previous values. Exactly 1000 and exactly 15938 are accepted.
- R3: The post-divider starts at 1. While the frequency is below 8000 the frequency and the post-divider are both doubled. `postdiv_o` is one-hot: 4'b0001=÷1, 4'b0010=÷2, 4'b0100=÷4, 4'b1000=÷8.
- R4: The feedback count is ((46·f·1000 div 1432) + 500) div 1000, where f is the normalised frequency and each division truncates.
- R5: `word_o[8:0]` holds the feedback count minus 257. This is never negative.
- R6: `word_o[10:9]` holds the post-divider code: 3 for ÷1, 2 for ÷2, 1 for ÷4, 0 for ÷8.
- R7: Every valid word has `word_o[12:11]`=2'b11 and `word_o[15:13]`=0.
- R8: Each accepted request gives exactly one `done_o` pulse of one cycle. A valid result clears `err_o`.
- R9: A `start_i` seen while a request is in progress is ignored. It produces no extra result and does not change the result being computed.
- R10: `word_o`, `postdiv_o` and `err_o` hold their values between `done_o` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| freq_i | input | 16 | Requested frequency in 0.01 MHz units |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | Last request was out of range |
| word_o | output | 16 | Packed synthesizer program word |
| postdiv_o | output | 4 | One-hot post-divider of the last valid word |

## Verification
A fault in the normalisation loop shows up as a wrong post-divider code, together with a count that is off by a factor of two. Both appear at the next `done_o`, roughly 75 cycles after the start. A divider fault corrupts the low nine bits of the word for almost every frequency. Requests near 1000, 7999, 8000 and 15938 expose errors in rounding and band edges. A controller that re-arms while busy is caught as an unexpected `done_o`, or as a result that belongs to a start which should have been ignored. That shows within one computation time of the ignored strobe.

// File: rtl/clk_word_pkg.sv
package clk_word_pkg;
    localparam int FREQ_W    = 16;
    localparam int WORD_W    = 16;
    localparam int NUM_W     = 32;
    localparam int DEN_W     = 11;
    localparam int CNT_W     = 10;
    localparam int LOW_W     = 9;
    localparam int PD_W      = 4;
    localparam int CODE_LSB  = 9;
    localparam int STOP_LSB  = 11;

    localparam int FREQ_MAX  = 15938;
    localparam int FREQ_MIN  = 1000;
    localparam int BAND_LO   = 8000;
    localparam int REF_MUL   = 46000;   // feedback scale times 1000
    localparam int REF_DIV   = 1432;
    localparam int ROUND_DIV = 1000;
    localparam int ROUND_ADD = 500;
    localparam int CNT_OFS   = 257;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_REJECT,
        ST_NORM,
        ST_SCALE,
        ST_SCALE_WAIT,
        ST_ROUND,
        ST_ROUND_WAIT,
        ST_EMIT
    } calc_state_e;
endpackage

// File: rtl/clk_word_range.sv
module clk_word_range #(
    parameter int FREQ_W = clk_word_pkg::FREQ_W
) (
    input  logic [FREQ_W-1:0] freq_i,
    output logic              too_high_o,
    output logic              too_low_o
);
    localparam logic [FREQ_W-1:0] HI_LIM = FREQ_W'(clk_word_pkg::FREQ_MAX);
    localparam logic [FREQ_W-1:0] LO_LIM = FREQ_W'(clk_word_pkg::FREQ_MIN);

    assign too_high_o = (freq_i > HI_LIM);
    assign too_low_o  = (freq_i < LO_LIM);
endmodule

// File: rtl/clk_word_div.sv
module clk_word_div #(
    parameter int NUM_W = clk_word_pkg::NUM_W,
    parameter int DEN_W = clk_word_pkg::DEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] sh_q;
    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;

    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;
    logic [DEN_W-1:0] rem_nxt;

    always_comb begin
        trial   = {rem_q, sh_q[NUM_W-1]};
        diff    = trial - {1'b0, den_q};
        fits    = (trial >= {1'b0, den_q});
        rem_nxt = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            num_q  <= '0;
            den_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i) begin
                sh_q   <= num_i;
                num_q  <= num_i;
                den_q  <= den_i;
                rem_q  <= '0;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                sh_q  <= {sh_q[NUM_W-2:0], fits};
                rem_q <= rem_nxt;
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quo_o  = sh_q;

    // R4
    div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ((64'(sh_q) * 64'(den_q) + 64'(rem_q)) == 64'(num_q)) && (rem_q < den_q));

    // R8
    div_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/clk_word_pack.sv
module clk_word_pack #(
    parameter int CNT_W  = clk_word_pkg::CNT_W,
    parameter int WORD_W = clk_word_pkg::WORD_W,
    parameter int PD_W   = clk_word_pkg::PD_W
) (
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [PD_W-1:0]   pd_i,
    output logic [WORD_W-1:0] word_o,
    output logic              under_o
);
    import clk_word_pkg::*;

    logic [CNT_W-1:0] adj;
    logic [1:0]       code;

    always_comb begin
        adj = cnt_i - CNT_W'(CNT_OFS);
        unique case (pd_i)
            4'b0001: code = 2'd3;
            4'b0010: code = 2'd2;
            4'b0100: code = 2'd1;
            default: code = 2'd0;
        endcase
        word_o = '0;
        word_o[STOP_LSB+1:STOP_LSB] = 2'b11;
        word_o[CODE_LSB+1:CODE_LSB] = code;
        word_o[LOW_W-1:0]           = adj[LOW_W-1:0];
        under_o = |adj[CNT_W-1:LOW_W];
    end
endmodule

// File: rtl/clk_word_calc.sv
module clk_word_calc
    import clk_word_pkg::*;
#(
    parameter int FREQ_W = clk_word_pkg::FREQ_W,
    parameter int WORD_W = clk_word_pkg::WORD_W,
    parameter int PD_W   = clk_word_pkg::PD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] freq_i,
    output logic              done_o,
    output logic              err_o,
    output logic [WORD_W-1:0] word_o,
    output logic [PD_W-1:0]   postdiv_o
);
    localparam logic [FREQ_W-1:0] BAND_EDGE = FREQ_W'(BAND_LO);
    localparam logic [FREQ_W-1:0] BAND_TOP  = FREQ_W'(2 * BAND_LO);

    calc_state_e state, nxt;

    logic [FREQ_W-1:0] f_q;
    logic [PD_W-1:0]   pd_q;
    logic [NUM_W-1:0]  q1_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              too_high, too_low, below_band;
    logic              div_go, div_done;
    logic [NUM_W-1:0]  div_num, div_quo;
    logic [DEN_W-1:0]  div_den;
    logic [WORD_W-1:0] pack_word;
    logic              pack_under;

    clk_word_range #(.FREQ_W(FREQ_W)) i_range (
        .freq_i     (f_q),
        .too_high_o (too_high),
        .too_low_o  (too_low)
    );

    assign below_band = (f_q < BAND_EDGE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (start_i) nxt = ST_CHECK;
            ST_CHECK:      nxt = (too_high || too_low) ? ST_REJECT : ST_NORM;
            ST_REJECT:     nxt = ST_IDLE;
            ST_NORM:       if (!below_band) nxt = ST_SCALE;
            ST_SCALE:      nxt = ST_SCALE_WAIT;
            ST_SCALE_WAIT: if (div_done) nxt = ST_ROUND;
            ST_ROUND:      nxt = ST_ROUND_WAIT;
            ST_ROUND_WAIT: if (div_done) nxt = ST_EMIT;
            ST_EMIT:       nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q   <= '0;
            pd_q  <= PD_W'(1);
            q1_q  <= '0;
            cnt_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        f_q  <= freq_i;
                        pd_q <= PD_W'(1);
                    end
                end
                ST_NORM: begin
                    if (below_band) begin
                        f_q  <= f_q << 1;
                        pd_q <= pd_q << 1;
                    end
                end
                ST_SCALE_WAIT: if (div_done) q1_q  <= div_quo;
                ST_ROUND_WAIT: if (div_done) cnt_q <= div_quo[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // shared divider operands
    always_comb begin
        div_go  = (state == ST_SCALE) || (state == ST_ROUND);
        if (state == ST_SCALE) begin
            div_num = NUM_W'(f_q) * NUM_W'(REF_MUL);
            div_den = DEN_W'(REF_DIV);
        end else begin
            div_num = q1_q + NUM_W'(ROUND_ADD);
            div_den = DEN_W'(ROUND_DIV);
        end
    end

    clk_word_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (div_go),
        .num_i  (div_num),
        .den_i  (div_den),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    clk_word_pack #(.CNT_W(CNT_W), .WORD_W(WORD_W), .PD_W(PD_W)) i_pack (
        .cnt_i   (cnt_q),
        .pd_i    (pd_q),
        .word_o  (pack_word),
        .under_o (pack_under)
    );

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            err_o     <= 1'b0;
            word_o    <= '0;
            postdiv_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (state == ST_EMIT) begin
                done_o    <= 1'b1;
                err_o     <= 1'b0;
                word_o    <= pack_word;
                postdiv_o <= pd_q;
            end else if (state == ST_REJECT) begin
                done_o <= 1'b1;
                err_o  <= 1'b1;
            end
        end
    end

    // R3
    band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCALE) |-> (f_q >= BAND_EDGE) && (f_q < BAND_TOP) && ($countones(pd_q) == 1));

    // R3
    pd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> ($countones(postdiv_o) == 1));

    // R5
    count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT) |-> !pack_under);

    // R7
    stop_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (word_o[STOP_LSB+1:STOP_LSB] == 2'b11) && (word_o[WORD_W-1:STOP_LSB+2] == '0));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> ($stable(word_o) && $stable(postdiv_o)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(word_o) && $stable(postdiv_o) && $stable(err_o)));
endmodule

// File: tb/test_clk_word_calc.sv
module test_clk_word_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] freq_i = '0;
    logic        done_o, err_o;
    logic [15:0] word_o;
    logic [3:0]  postdiv_o;

    always #2.5 clk = ~clk;   // 200 MHz

    clk_word_calc i_clk_word_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .freq_i    (freq_i),
        .done_o    (done_o),
        .err_o     (err_o),
        .word_o    (word_o),
        .postdiv_o (postdiv_o)
    );

    typedef struct packed {
        logic        err;
        logic [15:0] word;
        logic [3:0]  pd;
        logic [23:0] tag;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    logic [15:0] last_word = '0;
    logic [3:0]  last_pd = '0;
    bit          finished = 1'b0;
    logic        prev_done = 1'b0;

    function automatic exp_t predict(input int f, input logic [23:0] tag);
        exp_t e;
        longint x;
        int pd, code;
        longint cnt;
        e.tag = tag;
        if (f > 15938 || f < 1000) begin
            e.err = 1'b1; e.word = last_word; e.pd = last_pd;   // R2
        end else begin
            x = f; pd = 1;
            while (x < 8000) begin x = x * 2; pd = pd * 2; end      // R3
            cnt  = ((46 * x * 1000) / 1432 + 500) / 1000;          // R4
            code = (pd == 1) ? 3 : (pd == 2) ? 2 : (pd == 4) ? 1 : 0; // R6
            e.err  = 1'b0;
            e.word = 16'h1800 | 16'(code << 9) | 16'(cnt - 257);    // R5 R7
            e.pd   = 4'(pd);
            last_word = e.word;
            last_pd   = e.pd;
        end
        return e;
    endfunction

    task automatic pulse_start(input int f);
        @(negedge clk);
        freq_i  = 16'(f);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send(input int f, input logic [23:0] tag);
        sb_q.push_back(predict(f, tag));
        pulse_start(f);
        while (sb_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                checks++;
                if (prev_done) begin
                    errors++;
                    $display("FAIL R8: done high two cycles, actual 2 expected 1");
                end
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL R9: unexpected done, actual word %h expected no result", word_o);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (err_o !== e.err || word_o !== e.word || postdiv_o !== e.pd) begin
                        errors++;
                        $display("FAIL %s: actual err=%b word=%h pd=%b expected err=%b word=%h pd=%b",
                                 e.tag, err_o, word_o, postdiv_o, e.err, e.word, e.pd);
                    end
                end
            end
            prev_done <= done_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R8: watchdog expired, actual pending %0d expected 0", sb_q.size());
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (done_o !== 1'b0 || err_o !== 1'b0 || word_o !== 16'h0000 || postdiv_o !== 4'b0000) begin
            errors++;
            $display("FAIL R1: actual done=%b err=%b word=%h pd=%b expected 0 0 0000 0000",
                     done_o, err_o, word_o, postdiv_o);
        end

        send(12345, "R4");
        send(15938, "R2");   // upper edge accepted
        send(1000,  "R2");   // lower edge accepted, div 8
        send(8000,  "R6");
        send(7999,  "R5");   // largest count
        send(3999,  "R3");
        send(2500,  "R3");
        send(1999,  "R6");
        send(999,   "R2");   // rejected, word held
        send(15939, "R2");
        send(0,     "R2");
        send(65535, "R2");
        send(9876,  "R8");   // clears err

        // R9: second start while busy is ignored
        sb_q.push_back(predict(5000, "R9"));
        pulse_start(5000);
        repeat (3) @(negedge clk);
        pulse_start(9000);
        repeat (30) @(negedge clk);
        pulse_start(1500);
        while (sb_q.size() != 0) @(negedge clk);
        repeat (100) @(negedge clk);   // any stray done fails in the monitor

        // R10: outputs hold after a result
        send(4321, "R10");
        repeat (20) @(negedge clk);
        checks++;
        if (word_o !== last_word || postdiv_o !== last_pd || err_o !== 1'b0) begin
            errors++;
            $display("FAIL R10: actual word=%h pd=%b expected word=%h pd=%b",
                     word_o, postdiv_o, last_word, last_pd);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule